// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is an eight-stage (parameterisable) register with four operating modes: keep the stored word, move it one stage toward the high end with a serial bit entering the low end, move it one stage toward the low end with a serial bit entering the high end, or capture a whole word from a parallel port. Two mode inputs pick the operation, and every update happens on the rising clock edge. An active-low asynchronous reset clears all stages and takes precedence over everything else.

The parallel word travels over a single shared pin group. For synthesis that group appears as three signals: `p_in` (data seen on the pins), `p_out` (the register word) and `p_oe` (drive enable). The pins are driven with the register word only when both active-low enables are low and the block is not in load mode; in load mode the pins are always released so that an external source can present the word to be captured. The enables touch only the pin drivers, never the stored state. Two serial taps, the lowest stage and the highest stage, are always driven. The block is plain control and data with no streaming traffic, so no valid/ready handshake exists and there is no back-pressure.

Top module: `ushift_port`

## Requirements
- R1: The mode is the pair {sel_right, sel_left}: 00 keeps the word, 01 shifts toward stage 0, 10 shifts toward stage WIDTH-1, 11 loads from the port; in keep mode every stage holds its value across the rising edge.
- R2: In the 10 mode, at the rising edge stage 0 takes ser_in_r and stage i takes the old value of stage i-1.
- R3: In the 01 mode, at the rising edge stage WIDTH-1 takes ser_in_l and stage i takes the old value of stage i+1.
- R4: In the 11 mode, at the rising edge every stage i takes p_in[i].
- R5: p_oe is 1 exactly when oe_n_a and oe_n_b are both 0 and the mode is not 11; in the 11 mode p_oe is 0 whatever the enables are.
- R6: The enables have no effect on the stored word: keeping, shifting, loading and reset behave the same with p_oe at 0; p_out always carries the stored word (bit i = stage i).
- R7: rst_n low clears every stage to 0 at once, without a clock edge, and holds them at 0 across clock edges whatever the mode and data inputs are.
- R8: tap_first always equals stage 0 and tap_last always equals stage WIDTH-1, independent of the enables.
- R9: Serial inputs and p_in have no effect outside the modes that use them.
- R10: Mode and data inputs that change between rising edges and settle back before the next edge leave the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous clear |
| sel_right | input | 1 | Mode select, high bit of the mode pair |
| sel_left | input | 1 | Mode select, low bit of the mode pair |
| oe_n_a | input | 1 | Active-low pin enable, first of two |
| oe_n_b | input | 1 | Active-low pin enable, second of two |
| ser_in_r | input | 1 | Serial bit entering stage 0 when shifting up |
| ser_in_l | input | 1 | Serial bit entering stage WIDTH-1 when shifting down |
| p_in | input | WIDTH | Word seen on the shared pins |
| p_out | output | WIDTH | Stored word, driven onto the pins when p_oe is 1 |
| p_oe | output | 1 | Drive enable for the shared pins |
| tap_first | output | 1 | Stage 0, always driven |
| tap_last | output | 1 | Stage WIDTH-1, always driven |

## Verification
The interesting collision is the port turning around in load mode: in the same cycle the pins must be released (p_oe falls combinationally with the mode) while the register captures the word the outside world places on them, and this is provoked by sweeping every mode against every enable pair with a fresh p_in word each cycle, judging p_oe before the edge and p_out after it. A second collision is the asynchronous clear arriving mid-cycle while load mode and an all-ones p_in are present; the bench checks the word is zero before any edge and stays zero across an edge. Short input excursions between edges are also injected to show only edge-time values matter.

// File: rtl/ushp_pkg.sv
`timescale 1ns/1ps
package ushp_pkg;
  // Mode pair is {sel_right, sel_left}
  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_UP    = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;
endpackage

// File: rtl/ushp_mode_dec.sv
`timescale 1ns/1ps
module ushp_mode_dec
  import ushp_pkg::*;
(
  input  logic  sel_right,
  input  logic  sel_left,
  output mode_e mode
);
  always_comb begin
    unique case ({sel_right, sel_left})
      2'b00:   mode = MODE_KEEP;
      2'b01:   mode = MODE_DOWN;
      2'b10:   mode = MODE_UP;
      default: mode = MODE_LOAD;
    endcase
  end
endmodule

// File: rtl/ushp_cell.sv
`timescale 1ns/1ps
module ushp_cell
  import ushp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  up_src,    // value arriving when shifting toward high end
  input  logic  down_src,  // value arriving when shifting toward low end
  input  logic  load_src,
  output logic  q
);
  logic d;

  always_comb begin
    unique case (mode)
      MODE_UP:   d = up_src;
      MODE_DOWN: d = down_src;
      MODE_LOAD: d = load_src;
      default:   d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/ushp_port_drv.sv
`timescale 1ns/1ps
module ushp_port_drv
  import ushp_pkg::*;
(
  input  mode_e mode,
  input  logic  oe_n_a,
  input  logic  oe_n_b,
  output logic  p_oe
);
  logic en_ok;
  assign en_ok = ~(oe_n_a | oe_n_b);
  // The pins are released in load mode so the outside can drive them
  assign p_oe  = en_ok & (mode != MODE_LOAD);
endmodule

// File: rtl/ushift_port.sv
`timescale 1ns/1ps
module ushift_port
  import ushp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_right,
  input  logic             sel_left,
  input  logic             oe_n_a,
  input  logic             oe_n_b,
  input  logic             ser_in_r,
  input  logic             ser_in_l,
  input  logic [WIDTH-1:0] p_in,
  output logic [WIDTH-1:0] p_out,
  output logic             p_oe,
  output logic             tap_first,
  output logic             tap_last
);
  localparam int LAST = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] up_vec;
  logic [WIDTH-1:0] down_vec;

  ushp_mode_dec u_dec (
    .sel_right (sel_right),
    .sel_left  (sel_left),
    .mode      (mode)
  );

  assign up_vec   = {stage[LAST-1:0], ser_in_r};
  assign down_vec = {ser_in_l, stage[LAST:1]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    ushp_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .up_src   (up_vec[i]),
      .down_src (down_vec[i]),
      .load_src (p_in[i]),
      .q        (stage[i])
    );
  end

  ushp_port_drv u_drv (
    .mode   (mode),
    .oe_n_a (oe_n_a),
    .oe_n_b (oe_n_b),
    .p_oe   (p_oe)
  );

  assign p_out     = stage;
  assign tap_first = stage[0];
  assign tap_last  = stage[LAST];
endmodule

// File: rtl/ushp_chk.sv
`timescale 1ns/1ps
module ushp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_right,
  input logic             sel_left,
  input logic             oe_n_a,
  input logic             oe_n_b,
  input logic             ser_in_r,
  input logic             ser_in_l,
  input logic [WIDTH-1:0] p_in,
  input logic [WIDTH-1:0] p_out,
  input logic             p_oe
);
  assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_right && !sel_left) |=> (p_out == $past(p_out)));

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_right && !sel_left) |=> (p_out == {$past(p_out[WIDTH-2:0]), $past(ser_in_r)}));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_right && sel_left) |=> (p_out == {$past(ser_in_l), $past(p_out[WIDTH-1:1])}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_right && sel_left) |=> (p_out == $past(p_in)));

  assert_release_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_right && sel_left) |-> !p_oe);

  assert_release_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n_a || oe_n_b) |-> !p_oe);

  assert_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (p_out == '0));
endmodule

bind ushift_port ushp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_right (sel_right),
  .sel_left  (sel_left),
  .oe_n_a    (oe_n_a),
  .oe_n_b    (oe_n_b),
  .ser_in_r  (ser_in_r),
  .ser_in_l  (ser_in_l),
  .p_in      (p_in),
  .p_out     (p_out),
  .p_oe      (p_oe)
);

// File: tb/test_ushift_port.sv
`timescale 1ns/1ps
module test_ushift_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         sel_right = 1'b0, sel_left = 1'b0;
  logic         oe_n_a = 1'b1, oe_n_b = 1'b1;
  logic         ser_in_r = 1'b0, ser_in_l = 1'b0;
  logic [W-1:0] p_in = '0;
  logic [W-1:0] p_out;
  logic         p_oe, tap_first, tap_last;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ushift_port #(.WIDTH(W)) i_ushift_port (
    .clk(clk), .rst_n(rst_n), .sel_right(sel_right), .sel_left(sel_left),
    .oe_n_a(oe_n_a), .oe_n_b(oe_n_b), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
    .p_in(p_in), .p_out(p_out), .p_oe(p_oe), .tap_first(tap_first), .tap_last(tap_last)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_word(input string req);
    check(req, p_out, m);
    check("R8 taps", {6'b0, tap_last, tap_first}, {6'b0, m[W-1], m[0]});
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    #0.5;
    m = '0;
    check_word("R7 reset state");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // Sweep all modes x enable pairs x serial bits with a varying port word
    for (int i = 0; i < 2048; i++) begin
      logic [1:0] md;
      logic exp_oe;
      md        = i[1:0] ^ i[7:6];
      sel_right = md[1];
      sel_left  = md[0];
      oe_n_a    = i[2];
      oe_n_b    = i[3];
      ser_in_r  = i[4];
      ser_in_l  = i[5];
      p_in      = W'((i * 37 + 5) ^ (i >> 3));
      #1;
      exp_oe = !i[2] && !i[3] && (md != 2'b11);
      check("R5 p_oe", {7'b0, p_oe}, {7'b0, exp_oe});
      case (md)
        2'b00: m = m;                               // R1 / R9
        2'b10: m = {m[W-2:0], ser_in_r};            // R2
        2'b01: m = {ser_in_l, m[W-1:1]};            // R3
        default: m = p_in;                          // R4
      endcase
      @(negedge clk);
      case (md)
        2'b00: check_word((i[2] | i[3]) ? "R6 keep disabled" : "R1 keep / R9 ignore");
        2'b10: check_word((i[2] | i[3]) ? "R6 shift up disabled" : "R2 shift up");
        2'b01: check_word((i[2] | i[3]) ? "R6 shift down disabled" : "R3 shift down");
        default: check_word("R4 load");
      endcase
    end

    // R10: excursions between edges settle back to keep mode
    sel_right = 1'b0; sel_left = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #0.5;
      sel_right = k[0]; sel_left = 1'b1; p_in = ~m; ser_in_r = ~m[0]; ser_in_l = ~m[W-1];
      #0.5;
      sel_right = 1'b0; sel_left = 1'b0;
      @(negedge clk);
      check_word("R10 mid-cycle glitch");
    end

    // R7: asynchronous clear mid-cycle while load mode presents all ones
    sel_right = 1'b1; sel_left = 1'b1; p_in = '1; oe_n_a = 1'b0; oe_n_b = 1'b0;
    @(negedge clk);
    m = '1;
    check_word("R4 load all ones");
    #0.5 rst_n = 1'b0;
    #0.5;
    m = '0;
    check_word("R7 async clear");
    @(negedge clk);
    check_word("R7 clear overrides load");
    rst_n = 1'b1;
    @(negedge clk);
    m = '1;
    check_word("R4 load after clear");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule